// File: doc/BRIEF.md
# Masked Trigger Capture Receiver

This block watches several parallel word streams, one per receive channel, as they come out of deserializers. Each channel holds its own trigger word and a per-bit care mask, so bits the host does not care about take no part in the compare. One arm pulse puts every channel into the waiting state at once. After that, each channel looks for its own trigger independently. When it sees a match, it records the matching word and the words on the following clocks into its own capture buffer, up to a fixed window.

A host loads each channel's trigger and mask through a small word-wide write port and issues the arm pulse. It then watches per-channel status flags for armed, triggered and done. When a channel is done, the host reads its capture buffer one byte at a time by naming the channel, the entry and the byte lane. A new arm pulse discards whatever a channel holds or is busy recording, and starts that channel waiting again.

Top module: `cap_rx_top`

## Requirements
- R1: After reset every channel is idle with armed, triggered and done all 0. An idle channel never triggers, whatever data it receives.
- R2: An arm pulse sampled on a clock edge puts every channel into the waiting state, so armed reads 1 and triggered and done read 0 after that edge.
- R3: A waiting channel triggers on the first word where every bit with mask 1 equals the trigger bit. Bits with mask 0 are ignored, so an all-zero mask triggers on the first word.
- R4: The triggering word is stored at entry 0 and the words on the next DEPTH-1 (255) consecutive clocks at entries 1 to 255, one per clock.
- R5: Each channel uses only its own trigger and mask and triggers independently of the other channels.
- R6: After the last entry is written, done and triggered read 1 and armed reads 0. Done holds, and later data leaves the buffer unchanged, until the next arm.
- R7: An arm during a capture returns that channel to waiting with triggered 0. The next capture starts again at entry 0.
- R8: An arm issued to a done channel clears done.
- R9: rd_data_o shows, one clock after rd_ch_i/rd_addr_i/rd_byte_i are sampled, byte lane rd_byte_i of the addressed entry. Lane 0 is bits 7:0 and lane 3 is bits 27:24, with bits 7:4 of lane 3 reading 0.
- R10: The word present on the clock edge that samples arm is never captured, even when it matches.
- R11: A write with cfg_we_i high loads cfg_word_i into the trigger of channel cfg_ch_i when cfg_sel_i is 0, and into its mask when cfg_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm pulse for all channels |
| cfg_we_i | input | 1 | Trigger/mask write strobe |
| cfg_ch_i | input | CH_W | Channel written |
| cfg_sel_i | input | 1 | 0 = trigger word, 1 = care mask |
| cfg_word_i | input | WORD_W | Value written |
| rx_data_i | input | NUM_CH*WORD_W | Incoming words, channel g in bits g*WORD_W upward |
| rd_ch_i | input | CH_W | Readback channel |
| rd_addr_i | input | ADDR_W | Readback entry |
| rd_byte_i | input | BSEL_W | Readback byte lane |
| rd_data_o | output | 8 | Readback byte |
| armed_o | output | NUM_CH | Channel waiting for trigger |
| trig_o | output | NUM_CH | Channel has triggered (capturing or done) |
| done_o | output | NUM_CH | Channel capture complete |

## Verification
The bench builds the block with three channels, 28-bit words and the full 256-entry window. Three channels allow a channel with a random mask, a channel that triggers late and a channel with an all-zero mask that triggers on its first word, all in one armed run. The full window drives the entry counter through its wrap point, and with DEPTH=256 the last write lands in the final slot. Because the channel index is two bits wide for three channels, the unused channel code is also reachable on the write and read ports.

// File: rtl/cap_rx_pkg.sv
package cap_rx_pkg;

    localparam int DEF_NUM_CH = 4;
    localparam int DEF_WORD_W = 28;
    localparam int DEF_DEPTH  = 256;

    // configuration register selector
    localparam logic CFG_PATTERN = 1'b0;
    localparam logic CFG_MASK    = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic armed;
        logic trig;
        logic done;
    } cap_stat_t;

    function automatic cap_stat_t stat_of(input cap_state_e s);
        cap_stat_t r;
        r.armed = (s == ST_ARMED);
        r.trig  = (s == ST_CAPT) || (s == ST_DONE);
        r.done  = (s == ST_DONE);
        return r;
    endfunction

endpackage

// File: rtl/cap_trig_cmp.sv
module cap_trig_cmp #(
    parameter int WORD_W = cap_rx_pkg::DEF_WORD_W
) (
    input  logic [WORD_W-1:0] data_i,
    input  logic [WORD_W-1:0] pat_i,
    input  logic [WORD_W-1:0] care_i,
    output logic              hit_o
);
    logic [WORD_W-1:0] bit_ok;

    // a bit passes when it is not cared about or it equals the trigger bit
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign bit_ok[b] = !care_i[b] || (data_i[b] == pat_i[b]);
    end

    assign hit_o = &bit_ok;
endmodule

// File: rtl/cap_chan_fsm.sv
module cap_chan_fsm
    import cap_rx_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              hit_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output cap_stat_t         stat_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    cap_state_e        state_q;
    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (arm_i) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_ARMED: begin
                    if (hit_i) begin
                        state_q <= ST_CAPT;
                        cnt_q   <= ADDR_W'(1);
                    end
                end
                ST_CAPT: begin
                    cnt_q <= cnt_q + ADDR_W'(1);
                    if (cnt_q == LAST) state_q <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        we_o    = !arm_i && ((state_q == ST_ARMED && hit_i) || state_q == ST_CAPT);
        waddr_o = (state_q == ST_ARMED) ? '0 : cnt_q;
    end

    assign stat_o = stat_of(state_q);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !arm_i) |=> state_q == ST_IDLE);
    // R2
    arm_wait_chk: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (state_q == ST_ARMED && cnt_q == '0));
    // R4
    cap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPT && !arm_i && cnt_q != LAST)
        |=> (state_q == ST_CAPT && cnt_q == $past(cnt_q) + ADDR_W'(1)));
    // R6
    fill_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPT && !arm_i && cnt_q == LAST) |=> state_q == ST_DONE);
    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && !arm_i) |=> (state_q == ST_DONE && !we_o));
endmodule

// File: rtl/cap_buf.sv
module cap_buf #(
    parameter int WORD_W = cap_rx_pkg::DEF_WORD_W,
    parameter int DEPTH  = cap_rx_pkg::DEF_DEPTH,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/cap_rx_top.sv
module cap_rx_top
    import cap_rx_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int WORD_W = DEF_WORD_W,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int NBYTES = (WORD_W + 7) / 8,
    parameter int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     arm_i,
    input  logic                     cfg_we_i,
    input  logic [CH_W-1:0]          cfg_ch_i,
    input  logic                     cfg_sel_i,
    input  logic [WORD_W-1:0]        cfg_word_i,
    input  logic [NUM_CH*WORD_W-1:0] rx_data_i,
    input  logic [CH_W-1:0]          rd_ch_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    input  logic [BSEL_W-1:0]        rd_byte_i,
    output logic [7:0]               rd_data_o,
    output logic [NUM_CH-1:0]        armed_o,
    output logic [NUM_CH-1:0]        trig_o,
    output logic [NUM_CH-1:0]        done_o
);
    localparam int EXT_W = NBYTES * 8;

    logic [WORD_W-1:0] pat_q  [NUM_CH];
    logic [WORD_W-1:0] care_q [NUM_CH];
    logic [WORD_W-1:0] rword  [NUM_CH];
    logic [CH_W-1:0]   rch_q;
    logic [BSEL_W-1:0] rbyte_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic              hit;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        cap_stat_t         st;
        logic [WORD_W-1:0] din;

        assign din = rx_data_i[g*WORD_W +: WORD_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                pat_q[g]  <= '0;
                care_q[g] <= '0;
            end else if (cfg_we_i && cfg_ch_i == CH_W'(g)) begin
                if (cfg_sel_i == CFG_MASK) care_q[g] <= cfg_word_i;
                else                       pat_q[g]  <= cfg_word_i;
            end
        end

        cap_trig_cmp #(.WORD_W(WORD_W)) i_cmp (
            .data_i (din),
            .pat_i  (pat_q[g]),
            .care_i (care_q[g]),
            .hit_o  (hit)
        );

        cap_chan_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_fsm (
            .clk     (clk),
            .rst     (rst),
            .arm_i   (arm_i),
            .hit_i   (hit),
            .we_o    (we),
            .waddr_o (waddr),
            .stat_o  (st)
        );

        cap_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_buf (
            .clk     (clk),
            .we_i    (we),
            .waddr_i (waddr),
            .wdata_i (din),
            .raddr_i (rd_addr_i),
            .rdata_o (rword[g])
        );

        assign armed_o[g] = st.armed;
        assign trig_o[g]  = st.trig;
        assign done_o[g]  = st.done;

        // R6
        stat_excl_chk: assert property (@(posedge clk) disable iff (rst)
            done_o[g] |-> (trig_o[g] && !armed_o[g]));
        // R7
        rearm_clear_chk: assert property (@(posedge clk) disable iff (rst)
            arm_i |=> (armed_o[g] && !trig_o[g] && !done_o[g]));
    end

    // readback selection follows the memory read by one register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            rch_q   <= '0;
            rbyte_q <= '0;
        end else begin
            rch_q   <= rd_ch_i;
            rbyte_q <= rd_byte_i;
        end
    end

    logic [WORD_W-1:0] sel_word;
    logic [EXT_W-1:0]  ext_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rch_q == CH_W'(i)) sel_word = rword[i];
        end
        ext_word  = EXT_W'(sel_word);
        rd_data_o = ext_word[rbyte_q*8 +: 8];
    end
endmodule

// File: tb/test_cap_rx_top.sv
module test_cap_rx_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 3;
    localparam int WW    = 28;
    localparam int DEPTH = 256;
    localparam int SLEN  = 320;
    localparam int CHW   = 2;
    localparam int AW    = 8;
    localparam int BW    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              arm_i = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [CHW-1:0]    cfg_ch_i = '0;
    logic              cfg_sel_i = 1'b0;
    logic [WW-1:0]     cfg_word_i = '0;
    logic [NCH*WW-1:0] rx_data_i = '0;
    logic [CHW-1:0]    rd_ch_i = '0;
    logic [AW-1:0]     rd_addr_i = '0;
    logic [BW-1:0]     rd_byte_i = '0;
    logic [7:0]        rd_data_o;
    logic [NCH-1:0]    armed_o, trig_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [WW-1:0] strm [NCH][SLEN];
    logic [WW-1:0] pat  [NCH];
    logic [WW-1:0] msk  [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_rx_top #(.NUM_CH(NCH), .WORD_W(WW), .DEPTH(DEPTH)) i_cap_rx_top (
        .clk(clk), .rst(rst), .arm_i(arm_i),
        .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_sel_i(cfg_sel_i),
        .cfg_word_i(cfg_word_i), .rx_data_i(rx_data_i),
        .rd_ch_i(rd_ch_i), .rd_addr_i(rd_addr_i), .rd_byte_i(rd_byte_i),
        .rd_data_o(rd_data_o), .armed_o(armed_o), .trig_o(trig_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [WW-1:0] w, input int b);
        logic [31:0] e;
        e = 32'(w);
        return e[b*8 +: 8];
    endfunction

    function automatic logic [WW-1:0] no_hit(input logic [WW-1:0] w, input logic [WW-1:0] p,
                                             input logic [WW-1:0] m);
        if (((w ^ p) & m) == '0) return w ^ (m & (~m + 1'b1));
        return w;
    endfunction

    task automatic write_cfg(input int ch, input logic sel, input logic [WW-1:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_ch_i = CHW'(ch); cfg_sel_i = sel; cfg_word_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic build(input int ch, input int tidx);
        for (int k = 0; k < SLEN; k++) begin
            logic [WW-1:0] w;
            w = WW'($urandom);
            if (k == tidx)     w = (w & ~msk[ch]) | (pat[ch] & msk[ch]);
            else if (k < tidx) w = no_hit(w, pat[ch], msk[ch]);
            strm[ch][k] = w;
        end
    endtask

    task automatic drive(input int k);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) rx_data_i[c*WW +: WW] = strm[c][k];
    endtask

    task automatic pulse_arm(input logic [NCH*WW-1:0] d);
        @(negedge clk);
        arm_i = 1'b1; rx_data_i = d;
        @(posedge clk); #1;
        arm_i = 1'b0;
    endtask

    task automatic verify(input int ch, input int tidx, input string req);
        for (int e = 0; e < DEPTH; e++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                rd_ch_i = CHW'(ch); rd_addr_i = AW'(e); rd_byte_i = BW'(b);
                @(posedge clk); #1;
                chk(req, 32'(rd_data_o), 32'(exp_byte(strm[ch][tidx+e], b)));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 armed", 32'(armed_o), 0);
        chk("R1 trig", 32'(trig_o), 0);
        chk("R1 done", 32'(done_o), 0);

        // R11 load triggers and masks; channel 2 cares about no bit
        for (int c = 0; c < NCH; c++) begin
            pat[c] = WW'($urandom);
            msk[c] = (c == 2) ? '0 : (WW'($urandom) | WW'(1));
            write_cfg(c, 1'b0, pat[c]);
            write_cfg(c, 1'b1, msk[c]);
        end
        build(0, 5); build(1, 40); build(2, 0);

        // R1 idle channels ignore matching words
        @(negedge clk);
        rx_data_i[0 +: WW] = pat[0]; rx_data_i[WW +: WW] = pat[1];
        repeat (3) @(posedge clk); #1;
        chk("R1 idle no trigger", 32'(trig_o), 0);

        // R10 arm cycle carries a word matching channel 0
        pulse_arm({strm[2][1], pat[1], pat[0]});
        chk("R2 all armed", 32'(armed_o), 32'b111);
        chk("R10 arm word not taken", 32'(trig_o), 0);

        for (int k = 0; k < 300; k++) begin
            drive(k);
            @(posedge clk); #1;
            if (k == 0)   chk("R3 zero mask hits first word", 32'(trig_o[2]), 1);
            if (k == 4)   chk("R3 masked miss keeps armed", 32'(armed_o[0]), 1);
            if (k == 5)   chk("R3 masked hit", 32'({armed_o[0], trig_o[0]}), 32'b01);
            if (k == 39)  chk("R5 ch1 still waits", 32'({armed_o[1], trig_o[1]}), 32'b10);
            if (k == 40)  chk("R5 ch1 own trigger", 32'(trig_o[1]), 1);
            if (k == 259) chk("R4 window not full", 32'(done_o[0]), 0);
            if (k == 260) chk("R6 done after 256", 32'({armed_o[0], trig_o[0], done_o[0]}), 32'b011);
        end
        chk("R6 all done", 32'(done_o), 32'b111);
        verify(0, 5, "R4 ch0 capture");
        verify(1, 40, "R5 ch1 capture");
        verify(2, 0, "R6 ch2 capture");
        // R9 upper nibble of top lane is zero
        @(negedge clk); rd_ch_i = 2'd0; rd_addr_i = 8'd0; rd_byte_i = 2'd3;
        @(posedge clk); #1;
        chk("R9 top lane", 32'(rd_data_o[7:4]), 0);

        // R8 / R7 re-arm from done, then abort a capture
        pat[0] = WW'($urandom); write_cfg(0, 1'b0, pat[0]);
        build(0, 2);
        pulse_arm(rx_data_i);
        chk("R8 done cleared", 32'(done_o), 0);
        for (int k = 0; k < 50; k++) begin
            drive(k);
            @(posedge clk); #1;
        end
        chk("R7 capturing", 32'({trig_o[0], done_o[0]}), 32'b10);
        pulse_arm(rx_data_i);
        chk("R7 back to armed", 32'({armed_o[0], trig_o[0]}), 32'b10);
        build(0, 10);
        for (int k = 0; k < 280; k++) begin
            drive(k);
            @(posedge clk); #1;
        end
        chk("R7 recapture done", 32'(done_o[0]), 1);
        verify(0, 10, "R7 fresh capture");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule